// File: doc/BRIEF.md
# Packed RGB Pixel Unpacker

This block accepts a stream of 16-bit words holding pixels in one of several packed RGB layouts and turns them into 8:8:8 RGB pixels. Each produced pixel comes with a one-cycle valid strobe. A 4-bit format register picks the layout. It is written through a small write port and comes out of reset holding code 3. Code 1 is 5:6:5 at one word per pixel. Codes 2 and 3 carry two 24-bit pixels in three words. Codes 6 and 7 carry one 24-bit pixel in two words with one pad byte. Any other code is invalid: the block then produces nothing and raises an error flag.

Inside each word the low byte comes first. In the three-word layout the six bytes arrive in the order G0, R0, R1, B0, B1, G1. The first pixel is complete after the second word and the second pixel after the third word. In the two-word layout the four bytes arrive as R, pad, B, G.

A sequencer tracks the position inside the current group. Its states are:
- `ST_W0`: waiting for the first word of a group.
- `ST_W1`: waiting for the second word.
- `ST_W2`: waiting for the third word, three-word layout only.
- `ST_BAD`: the format code is invalid.

Its transitions are:
- A format write moves to `ST_W0`, or to `ST_BAD` when the new code is invalid.
- An accepted word moves `ST_W0` to `ST_W1`, except in 5:6:5, where the state stays in `ST_W0`.
- An accepted word moves `ST_W1` to `ST_W2` in the three-word layout, and back to `ST_W0` in the two-word layout.
- An accepted word moves `ST_W2` back to `ST_W0`.
- `ST_BAD` is left only by a format write.

Top module: `pix_unpack`

## Requirements
- R1: After reset the format code is 3 (three-word layout), pix_vld is 0, fmt_err is 0 and pix_r, pix_g and pix_b are 0.
- R2: With code 1, every accepted word gives one pixel in the next cycle. Red is word bits 15:11 followed by three zero bits. Green is bits 10:5 followed by two zero bits. Blue is bits 4:0 followed by three zero bits.
- R3: With the three-word layout, word 1 carries G0 in bits 7:0 and R0 in bits 15:8. Word 2 carries R1 in bits 7:0 and B0 in bits 15:8. Word 3 carries B1 in bits 7:0 and G1 in bits 15:8. Pixel 0 appears in the cycle after word 2 and pixel 1 in the cycle after word 3.
- R4: With the two-word layout, word 1 carries R in bits 7:0 and a pad byte in bits 15:8. Word 2 carries B in bits 7:0 and G in bits 15:8. The pad byte never reaches the output, and the pixel appears in the cycle after word 2.
- R5: Codes 2 and 3 both select the three-word layout, and codes 6 and 7 both select the two-word layout.
- R6: With any code other than 1, 2, 3, 6 or 7, fmt_err is 1 and pix_vld stays 0 for any input words.
- R7: A format write restarts the group at its first word. A word presented in the same cycle as a format write is dropped.
- R8: Cycles with word_vld low neither advance the group nor produce a pixel.
- R9: pix_r, pix_g and pix_b keep their last value in every cycle in which pix_vld is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_we | input | 1 | Write strobe for the format register |
| fmt_wdata | input | 4 | New format code |
| word_vld | input | 1 | Input word is present this cycle |
| word_data | input | 16 | Input word, low byte first |
| pix_vld | output | 1 | One-cycle strobe for a new pixel |
| pix_r | output | 8 | Red channel |
| pix_g | output | 8 | Green channel |
| pix_b | output | 8 | Blue channel |
| fmt_err | output | 1 | Current format code is invalid |

## Verification
A pixel strobe and its colour values are due one clock after the edge that accepts the word completing the pixel. fmt_err follows the format register one clock after the edge that accepts the write. The bench applies inputs at the falling edge, so both of these results are due at the next falling edge, one rising edge later. At that falling edge the bench compares every output against a byte-queue model that it updates at the rising edge in between.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;

    localparam int CODE_W    = 4;
    localparam int CH_W      = 8;
    localparam int WORD_W    = 2 * CH_W;
    localparam logic [CODE_W-1:0] FMT_RESET = 4'd3;

    typedef enum logic [1:0] {
        MODE_BAD,
        MODE_565,
        MODE_PAIR,
        MODE_PAD
    } mode_e;

    typedef enum logic [1:0] {
        ST_W0,
        ST_W1,
        ST_W2,
        ST_BAD
    } state_e;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_LOAD,
        ACT_EMIT_565,
        ACT_EMIT_SPLIT,
        ACT_EMIT_TAIL
    } act_e;

    function automatic mode_e decode_fmt(input logic [CODE_W-1:0] code);
        mode_e m;
        case (code)
            4'd1:       m = MODE_565;
            4'd2, 4'd3: m = MODE_PAIR;
            4'd6, 4'd7: m = MODE_PAD;
            default:    m = MODE_BAD;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pix_unpack_fmt_reg.sv
module pix_unpack_fmt_reg
    import pix_unpack_pkg::*;
#(
    parameter int                CW        = CODE_W,
    parameter logic [CW-1:0]     RESET_VAL = FMT_RESET
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fmt_we,
    input  logic [CW-1:0] fmt_wdata,
    output logic [CW-1:0] fmt_q,
    output mode_e         mode,
    output mode_e         new_mode
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            fmt_q <= RESET_VAL;
        else if (fmt_we)
            fmt_q <= fmt_wdata;
    end

    always_comb begin
        mode     = decode_fmt(fmt_q);
        new_mode = decode_fmt(fmt_wdata);
    end

endmodule

// File: rtl/pix_unpack_seq.sv
module pix_unpack_seq
    import pix_unpack_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   fmt_we,
    input  mode_e  new_mode,
    input  mode_e  mode,
    input  logic   word_vld,
    output act_e   act
);

    state_e state_q;
    state_e state_d;

    // next-state logic and state register
    always_comb begin
        state_d = state_q;
        if (fmt_we) begin
            state_d = (new_mode == MODE_BAD) ? ST_BAD : ST_W0;
        end else if (word_vld) begin
            unique case (state_q)
                ST_W0:  state_d = (mode == MODE_565) ? ST_W0 : ST_W1;
                ST_W1:  state_d = (mode == MODE_PAIR) ? ST_W2 : ST_W0;
                ST_W2:  state_d = ST_W0;
                ST_BAD: state_d = ST_BAD;
                default: state_d = ST_BAD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= (decode_fmt(FMT_RESET) == MODE_BAD) ? ST_BAD : ST_W0;
        else
            state_q <= state_d;
    end

    // action decode for the datapath
    always_comb begin
        act = ACT_IDLE;
        if (word_vld && !fmt_we) begin
            unique case (state_q)
                ST_W0:  act = (mode == MODE_565) ? ACT_EMIT_565 : ACT_LOAD;
                ST_W1:  act = (mode == MODE_PAIR) ? ACT_EMIT_SPLIT : ACT_EMIT_TAIL;
                ST_W2:  act = ACT_EMIT_TAIL;
                ST_BAD: act = ACT_IDLE;
                default: act = ACT_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pix_unpack_path.sv
module pix_unpack_path
    import pix_unpack_pkg::*;
#(
    parameter int CW = CH_W,
    localparam int WW = 2 * CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  act_e          act,
    input  logic [WW-1:0] word,
    output logic          pix_vld,
    output logic [CW-1:0] pix_r,
    output logic [CW-1:0] pix_g,
    output logic [CW-1:0] pix_b
);

    logic [CW-1:0] lo_b;
    logic [CW-1:0] hi_b;
    logic [CW-1:0] hold_a;
    logic [CW-1:0] hold_b;

    assign lo_b = word[CW-1:0];
    assign hi_b = word[WW-1:CW];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_a  <= '0;
            hold_b  <= '0;
            pix_vld <= 1'b0;
            pix_r   <= '0;
            pix_g   <= '0;
            pix_b   <= '0;
        end else begin
            pix_vld <= 1'b0;
            unique case (act)
                ACT_IDLE: ;
                ACT_LOAD: begin
                    hold_a <= lo_b;
                    hold_b <= hi_b;
                end
                ACT_EMIT_565: begin
                    pix_vld <= 1'b1;
                    pix_r   <= {word[15:11], {(CW-5){1'b0}}};
                    pix_g   <= {word[10:5],  {(CW-6){1'b0}}};
                    pix_b   <= {word[4:0],   {(CW-5){1'b0}}};
                end
                ACT_EMIT_SPLIT: begin
                    pix_vld <= 1'b1;
                    pix_r   <= hold_b;
                    pix_g   <= hold_a;
                    pix_b   <= hi_b;
                    hold_a  <= lo_b;
                end
                ACT_EMIT_TAIL: begin
                    pix_vld <= 1'b1;
                    pix_r   <= hold_a;
                    pix_g   <= hi_b;
                    pix_b   <= lo_b;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
    import pix_unpack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fmt_we,
    input  logic [CODE_W-1:0] fmt_wdata,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_data,
    output logic              pix_vld,
    output logic [CH_W-1:0]   pix_r,
    output logic [CH_W-1:0]   pix_g,
    output logic [CH_W-1:0]   pix_b,
    output logic              fmt_err
);

    logic [CODE_W-1:0] fmt_q;
    mode_e             mode;
    mode_e             new_mode;
    act_e              act;

    pix_unpack_fmt_reg #(.CW(CODE_W), .RESET_VAL(FMT_RESET)) i_fmt (
        .clk      (clk),
        .rst_n    (rst_n),
        .fmt_we   (fmt_we),
        .fmt_wdata(fmt_wdata),
        .fmt_q    (fmt_q),
        .mode     (mode),
        .new_mode (new_mode)
    );

    pix_unpack_seq i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .fmt_we  (fmt_we),
        .new_mode(new_mode),
        .mode    (mode),
        .word_vld(word_vld),
        .act     (act)
    );

    pix_unpack_path #(.CW(CH_W)) i_path (
        .clk    (clk),
        .rst_n  (rst_n),
        .act    (act),
        .word   (word_data),
        .pix_vld(pix_vld),
        .pix_r  (pix_r),
        .pix_g  (pix_g),
        .pix_b  (pix_b)
    );

    assign fmt_err = (mode == MODE_BAD);

endmodule

// File: rtl/pix_unpack_chk.sv
module pix_unpack_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fmt_we,
    input logic       word_vld,
    input logic       pix_vld,
    input logic [7:0] pix_r,
    input logic [7:0] pix_g,
    input logic [7:0] pix_b,
    input logic       fmt_err,
    input logic [3:0] fmt_q
);

    // R6
    no_pix_when_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |-> !fmt_err);

    // R8
    pix_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |-> $past(word_vld) && !$past(fmt_we));

    // R7
    no_pix_after_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fmt_we) |-> !pix_vld);

    // R9
    hold_colour_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_vld |-> $stable(pix_r) && $stable(pix_g) && $stable(pix_b));

    // R2
    zero_fill_565_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld && fmt_q == 4'd1) |-> (pix_r[2:0] == 3'b0 && pix_g[1:0] == 2'b0 && pix_b[2:0] == 3'b0));

endmodule

bind pix_unpack pix_unpack_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .fmt_we  (fmt_we),
    .word_vld(word_vld),
    .pix_vld (pix_vld),
    .pix_r   (pix_r),
    .pix_g   (pix_g),
    .pix_b   (pix_b),
    .fmt_err (fmt_err),
    .fmt_q   (fmt_q)
);

// File: tb/test_pix_unpack.sv
module test_pix_unpack;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fmt_we;
    logic [3:0]  fmt_wdata;
    logic        word_vld;
    logic [15:0] word_data;
    logic        pix_vld;
    logic [7:0]  pix_r, pix_g, pix_b;
    logic        fmt_err;

    int checks = 0;
    int errors = 0;
    string req = "R1";

    // reference model state
    int       m_fmt = 3;
    int       bq[$];
    logic       e_vld = 1'b0;
    logic [7:0] e_r = 8'h0, e_g = 8'h0, e_b = 8'h0;

    always #4 clk = ~clk;

    pix_unpack i_pix_unpack (
        .clk(clk), .rst_n(rst_n), .fmt_we(fmt_we), .fmt_wdata(fmt_wdata),
        .word_vld(word_vld), .word_data(word_data), .pix_vld(pix_vld),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .fmt_err(fmt_err)
    );

    function automatic bit bad_code(input int c);
        return !(c == 1 || c == 2 || c == 3 || c == 6 || c == 7);
    endfunction

    task automatic model_edge();
        e_vld = 1'b0;
        if (fmt_we) begin
            m_fmt = int'(fmt_wdata);
            bq.delete();
        end else if (word_vld && !bad_code(m_fmt)) begin
            bq.push_back(int'(word_data[7:0]));
            bq.push_back(int'(word_data[15:8]));
            if (m_fmt == 1) begin
                e_vld = 1'b1;
                e_r = {word_data[15:11], 3'b000};
                e_g = {word_data[10:5], 2'b00};
                e_b = {word_data[4:0], 3'b000};
                bq.delete();
            end else if (m_fmt == 6 || m_fmt == 7) begin
                if (bq.size() == 4) begin
                    e_vld = 1'b1;
                    e_r = 8'(bq[0]); e_b = 8'(bq[2]); e_g = 8'(bq[3]);
                    bq.delete();
                end
            end else begin
                if (bq.size() == 4) begin
                    e_vld = 1'b1;
                    e_r = 8'(bq[1]); e_g = 8'(bq[0]); e_b = 8'(bq[3]);
                end else if (bq.size() == 6) begin
                    e_vld = 1'b1;
                    e_r = 8'(bq[2]); e_g = 8'(bq[5]); e_b = 8'(bq[4]);
                    bq.delete();
                end
            end
        end
    endtask

    task automatic compare();
        logic [25:0] act, exp;
        act = {pix_vld, pix_r, pix_g, pix_b, fmt_err};
        exp = {e_vld, e_r, e_g, e_b, 1'(bad_code(m_fmt))};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s vld/r/g/b/err actual %b/%h/%h/%h/%b expected %b/%h/%h/%h/%b",
                     req, act[25], act[24:17], act[16:9], act[8:1], act[0],
                     exp[25], exp[24:17], exp[16:9], exp[8:1], exp[0]);
        end
    endtask

    task automatic step(input logic we, input logic [3:0] code,
                        input logic vld, input logic [15:0] d);
        fmt_we = we; fmt_wdata = code; word_vld = vld; word_data = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input logic [15:0] d);
        step(1'b0, 4'd0, 1'b1, d);
    endtask

    task automatic idle();
        step(1'b0, 4'd0, 1'b0, 16'h0);
    endtask

    task automatic setfmt(input logic [3:0] c);
        step(1'b1, c, 1'b0, 16'h0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; fmt_we = 1'b0; fmt_wdata = 4'd0; word_vld = 1'b0; word_data = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        req = "R1";
        compare();
        idle();
        // R1, R3: default code is the three-word layout
        req = "R3";
        wr(16'h2211); wr(16'h4433); wr(16'h6655);
        wr(16'hB0A0); wr(16'hD0C0); wr(16'hF0E0);
        // R8: gaps inside a group
        req = "R8";
        wr(16'h1201); idle(); idle(); wr(16'h3423); idle(); wr(16'h5645); idle();
        // R2: 5:6:5 expansion
        req = "R2";
        setfmt(4'd1);
        wr(16'hFFFF); wr(16'h8421); wr(16'h0000); idle(); wr(16'h07E0); wr(16'hF81F);
        // R4: two-word layout with pad
        req = "R4";
        setfmt(4'd6);
        wr(16'hAA12); wr(16'h3456); wr(16'hFF9A); idle(); wr(16'hBCDE);
        // R5: alias codes
        req = "R5";
        setfmt(4'd7);
        wr(16'h5511); wr(16'h3322);
        setfmt(4'd2);
        wr(16'h0A0B); wr(16'h0C0D); wr(16'h0E0F);
        // R6: invalid codes give nothing
        req = "R6";
        for (int c = 0; c < 16; c++) begin
            if (bad_code(c)) begin
                setfmt(4'(c));
                wr(16'h1234); wr(16'h5678); wr(16'h9ABC); idle();
            end
        end
        // R7: format write restarts the group and drops a concurrent word
        req = "R7";
        setfmt(4'd3);
        wr(16'h7788);
        step(1'b1, 4'd3, 1'b1, 16'h9999);
        wr(16'h2211); wr(16'h4433); wr(16'h6655);
        setfmt(4'd6);
        wr(16'h0011);
        setfmt(4'd6);
        wr(16'h0044); wr(16'h6655);
        // R9: held colour over idle cycles
        req = "R9";
        idle(); idle(); idle();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule